// File: doc/BRIEF.md
# Collision Backoff Controller

This block decides when a station on a shared, collision-prone line may start another transmission attempt. Each collision reported by the line monitor is recorded in a shift-in history register. A jam phase follows. Once the jam has been sent, a backoff counter is loaded and then counts down one step per slot time. Transmission is permitted again only when that counter is at zero and the line has been idle for a full interframe space.

Two backoff policies are available. In the random policy, the load value is a pseudo-random number masked by the collision history, so the possible waiting window doubles with every collision. In the deterministic policy, the wait depends on the station's 6-bit slot number: a higher slot number waits fewer slot times. The jam waits for any preamble or start flag in progress to finish, and it can be sent either as a steady low level or as the CRC. After the maximum number of attempts, the transmitter is disabled until the next frame begins.

Top module: `coll_backoff`

## Requirements
- R1: Each accepted collision shifts a 1 into the history register from the least significant end (k collisions give 2^k-1). Reset and `frame_start_i` clear the register to 0.
- R2: A collision reported while the controller is waiting to jam or is jamming is ignored, and the history register stays unchanged.
- R3: After a collision, the jam starts on the first `bit_tick_i` seen while `hdr_busy_i` is low. It lasts exactly JAM_BITS bit ticks.
- R4: `jam_crc_o` equals `jam_o & jam_crc_cfg_i`: 1 means the jam carries the CRC, and 0 means the line is held at a low level. It is 0 whenever no jam is active.
- R5: In deterministic mode (`det_mode_i`=1), the backoff counter is loaded with 63 minus `my_slot_i` when the jam ends. Slot 63 waits no slot times and slot 1 waits the longest.
- R6: In deterministic mode with `my_slot_i`=0, `tx_permit_o` stays low after a collision.
- R7: In random mode, the loaded backoff value has no bit set outside the set bits of the history register.
- R8: The backoff counter decreases by one on each `slot_tick_i` while it is non-zero and no jam is pending. It holds at 0. It is visible on `backoff_o` and has no write port.
- R9: The interframe space expires after IFS_BITS consecutive bit ticks with `line_idle_i` high. A busy line restarts the count.
- R10: `tx_permit_o` is high exactly when no jam is pending or active, the backoff counter is 0, the interframe space has expired, the transmitter is not disabled, and R6 does not apply.
- R11: The collision that fills the history register (the 8th) sets `tx_disable_o`, which blocks the permit. The jam is still sent. `frame_start_i` clears the disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coll_i | input | 1 | Collision-detect strobe |
| hdr_busy_i | input | 1 | Preamble or start flag still being sent |
| bit_tick_i | input | 1 | One strobe per bit time |
| slot_tick_i | input | 1 | One strobe per slot time |
| line_idle_i | input | 1 | Line sensed idle |
| frame_start_i | input | 1 | New frame: clears history, backoff and disable |
| det_mode_i | input | 1 | 1 selects deterministic slot backoff, 0 selects random |
| my_slot_i | input | 6 | Station slot number, 0 forbids deterministic retry |
| jam_crc_cfg_i | input | 1 | Jam type: 1 sends the CRC, 0 sends a low level |
| tx_permit_o | output | 1 | Transmission may start |
| jam_o | output | 1 | Jam is active |
| jam_crc_o | output | 1 | Active jam carries the CRC |
| tx_disable_o | output | 1 | Retry limit reached |
| backoff_o | output | 8 | Current backoff count in slot times |
| coll_hist_o | output | 8 | Collision history register |

## Verification
The hardest state to reach from the ports is the retry limit. It needs eight complete collision, jam and backoff rounds in one frame, and each random countdown must run to zero through slot ticks of an unknown length. The stimulus loops over collisions. After each jam it reads the loaded count from `backoff_o`, checks it against the history mask, and then issues exactly that many slot ticks before the next collision. The deterministic mode is swept over all 64 slot numbers, including the slot-0 lockout.

// File: rtl/bk_pkg.sv
package bk_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_JAM  = 2'd2
    } bk_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/bk_history.sv
module bk_history #(
    parameter int unsigned TRIES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             acc_i,
    output logic [TRIES-1:0] hist_o,
    output logic             dis_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            hist_o <= '0;
            dis_o  <= 1'b0;
        end else if (acc_i) begin
            hist_o <= {hist_o[TRIES-2:0], 1'b1};
            if (hist_o[TRIES-2]) dis_o <= 1'b1;
        end
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (acc_i && !clr_i) |=> (hist_o == {$past(hist_o[TRIES-2:0]), 1'b1})); // R1
    AST_DIS_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(dis_o) |-> (&hist_o)); // R11
endmodule

// File: rtl/bk_lfsr.sv
module bk_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] rnd_o
);
    always_ff @(posedge clk) begin
        if (rst) rnd_o <= SEED;
        else     rnd_o <= {1'b0, rnd_o[15:1]} ^ (rnd_o[0] ? 16'hB400 : 16'h0000);
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        rnd_o != 16'h0000); // R7
endmodule

// File: rtl/bk_ifs.sv
module bk_ifs #(
    parameter int unsigned IFS_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic idle_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(IFS_BITS + 1);
    localparam logic [CW-1:0] LIM = CW'(IFS_BITS);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !idle_i)             cnt <= '0;
        else if (tick_i && cnt != LIM)  cnt <= cnt + 1'b1;
    end
    assign done_o = (cnt == LIM);

    AST_IFS_RESTART: assert property (@(posedge clk) disable iff (rst)
        !idle_i |=> !done_o); // R9
endmodule

// File: rtl/coll_backoff.sv
module coll_backoff
    import bk_pkg::*;
#(
    parameter int unsigned TRIES    = 8,
    parameter int unsigned NSLOT    = 64,
    parameter int unsigned JAM_BITS = 32,
    parameter int unsigned IFS_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       coll_i,
    input  logic       hdr_busy_i,
    input  logic       bit_tick_i,
    input  logic       slot_tick_i,
    input  logic       line_idle_i,
    input  logic       frame_start_i,
    input  logic       det_mode_i,
    input  logic [5:0] my_slot_i,
    input  logic       jam_crc_cfg_i,
    output logic       tx_permit_o,
    output logic       jam_o,
    output logic       jam_crc_o,
    output logic       tx_disable_o,
    output logic [7:0] backoff_o,
    output logic [7:0] coll_hist_o
);
    localparam int unsigned SLOT_W = $clog2(NSLOT);
    localparam int unsigned BO_W   = max2(TRIES, SLOT_W);
    localparam int unsigned JC_W   = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
    localparam logic [BO_W-1:0] TOP_SLOT = BO_W'(NSLOT - 1);

    bk_state_t          state;
    logic [JC_W-1:0]    jcnt;
    logic [BO_W-1:0]    bo, bo_load;
    logic [TRIES-1:0]   hist;
    logic [15:0]        rnd;
    logic               dis, ifs_done, acc, slot0_lock;

    assign acc = coll_i && (state == ST_RUN) && !frame_start_i;

    bk_history #(.TRIES(TRIES)) u_hist (
        .clk(clk), .rst(rst), .clr_i(frame_start_i), .acc_i(acc),
        .hist_o(hist), .dis_o(dis)
    );

    bk_lfsr u_rnd (.clk(clk), .rst(rst), .rnd_o(rnd));

    bk_ifs #(.IFS_BITS(IFS_BITS)) u_ifs (
        .clk(clk), .rst(rst), .idle_i(line_idle_i), .tick_i(bit_tick_i),
        .done_o(ifs_done)
    );

    always_comb begin
        if (det_mode_i) bo_load = TOP_SLOT - BO_W'(my_slot_i);
        else            bo_load = rnd[BO_W-1:0] & BO_W'(hist);
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start_i) begin
            state <= ST_RUN;
            jcnt  <= '0;
            bo    <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (coll_i)                        state <= ST_HOLD;
                    else if (slot_tick_i && bo != '0)  bo <= bo - 1'b1;
                end
                ST_HOLD: begin
                    if (bit_tick_i && !hdr_busy_i) begin
                        state <= ST_JAM;
                        jcnt  <= JC_W'(JAM_BITS - 1);
                    end
                end
                ST_JAM: begin
                    if (bit_tick_i) begin
                        if (jcnt == '0) begin
                            state <= ST_RUN;
                            bo    <= bo_load;
                        end else begin
                            jcnt <= jcnt - 1'b1;
                        end
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign slot0_lock   = det_mode_i && (my_slot_i == 6'd0) && (hist != '0);
    assign tx_permit_o  = (state == ST_RUN) && (bo == '0) && ifs_done && !dis && !slot0_lock;
    assign jam_o        = (state == ST_JAM);
    assign jam_crc_o    = jam_o && jam_crc_cfg_i;
    assign tx_disable_o = dis;
    assign backoff_o    = 8'(bo);
    assign coll_hist_o  = 8'(hist);

    AST_JAM_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        $rose(jam_o) |-> ($past(bit_tick_i) && !$past(hdr_busy_i))); // R3
    AST_BO_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && slot_tick_i && bo != '0 && !coll_i && !frame_start_i)
        |=> (bo == $past(bo) - 1'b1)); // R8
    AST_RAND_MASK: assert property (@(posedge clk) disable iff (rst)
        (!det_mode_i && $past(state) == ST_JAM && state == ST_RUN)
        |-> ((bo & ~BO_W'(hist)) == '0)); // R7
    AST_PERMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_permit_o |-> $past(line_idle_i)); // R10
endmodule

// File: tb/coll_backoff_test.sv
module coll_backoff_test;
    localparam int JAM = 32;
    localparam int IFS = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, coll_i, hdr_busy_i, bit_tick_i, slot_tick_i, line_idle_i;
    logic frame_start_i, det_mode_i, jam_crc_cfg_i;
    logic [5:0] my_slot_i;
    logic tx_permit_o, jam_o, jam_crc_o, tx_disable_o;
    logic [7:0] backoff_o, coll_hist_o;

    coll_backoff uut (
        .clk(clk), .rst(rst), .coll_i(coll_i), .hdr_busy_i(hdr_busy_i),
        .bit_tick_i(bit_tick_i), .slot_tick_i(slot_tick_i), .line_idle_i(line_idle_i),
        .frame_start_i(frame_start_i), .det_mode_i(det_mode_i), .my_slot_i(my_slot_i),
        .jam_crc_cfg_i(jam_crc_cfg_i), .tx_permit_o(tx_permit_o), .jam_o(jam_o),
        .jam_crc_o(jam_crc_o), .tx_disable_o(tx_disable_o), .backoff_o(backoff_o),
        .coll_hist_o(coll_hist_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask
    task automatic pb();
        bit_tick_i = 1'b1; step(); bit_tick_i = 1'b0;
    endtask
    task automatic ps();
        slot_tick_i = 1'b1; step(); slot_tick_i = 1'b0;
    endtask
    task automatic pc();
        coll_i = 1'b1; step(); coll_i = 1'b0;
    endtask
    task automatic pf();
        frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    endtask

    // collision with header already done, full jam, backoff loaded
    task automatic do_coll();
        pc();
        pb();
        chk("R3 jam start", int'(jam_o), 1);
        chk("R4 jam type", int'(jam_crc_o), int'(jam_crc_cfg_i));
        repeat (JAM) pb();
        chk("R3 jam end", int'(jam_o), 0);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; coll_i = 0; hdr_busy_i = 0; bit_tick_i = 0; slot_tick_i = 0;
        line_idle_i = 0; frame_start_i = 0; det_mode_i = 0; jam_crc_cfg_i = 0;
        my_slot_i = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R10 reset permit", int'(tx_permit_o), 0);
        chk("R3 reset jam", int'(jam_o), 0);
        chk("R1 reset hist", int'(coll_hist_o), 0);
        chk("R8 reset backoff", int'(backoff_o), 0);
        chk("R11 reset disable", int'(tx_disable_o), 0);

        // R9 interframe space
        line_idle_i = 1'b1;
        repeat (IFS - 1) pb();
        chk("R9 ifs short", int'(tx_permit_o), 0);
        pb();
        chk("R9 ifs full", int'(tx_permit_o), 1);
        line_idle_i = 1'b0; step();
        chk("R9 busy line", int'(tx_permit_o), 0);
        line_idle_i = 1'b1;
        repeat (IFS - 1) pb();
        chk("R9 restart short", int'(tx_permit_o), 0);
        pb();
        chk("R9 restart full", int'(tx_permit_o), 1);

        // R3 / R4 / R2 jam sequencing
        jam_crc_cfg_i = 1'b1;
        hdr_busy_i = 1'b1;
        pc();
        chk("R1 first shift", int'(coll_hist_o), 1);
        chk("R10 no permit pending", int'(tx_permit_o), 0);
        pc();
        chk("R2 ignored in hold", int'(coll_hist_o), 1);
        repeat (3) pb();
        chk("R3 wait header", int'(jam_o), 0);
        hdr_busy_i = 1'b0; step();
        chk("R3 wait bit tick", int'(jam_o), 0);
        pb();
        chk("R3 jam begins", int'(jam_o), 1);
        chk("R4 crc jam", int'(jam_crc_o), 1);
        pc();
        chk("R2 ignored in jam", int'(coll_hist_o), 1);
        repeat (JAM - 1) pb();
        chk("R3 jam length", int'(jam_o), 1);
        pb();
        chk("R3 jam over", int'(jam_o), 0);
        chk("R4 crc off", int'(jam_crc_o), 0);

        // R5 / R6 / R8 deterministic sweep over every slot
        jam_crc_cfg_i = 1'b0;
        det_mode_i = 1'b1;
        for (int s = 0; s < 64; s++) begin
            pf();
            my_slot_i = 6'(s);
            do_coll();
            chk("R5 slot load", int'(backoff_o), 63 - s);
            if (s == 0) begin
                repeat (70) ps();
                chk("R8 counted out", int'(backoff_o), 0);
                chk("R6 slot zero lock", int'(tx_permit_o), 0);
            end else begin
                if (63 - s > 1) begin
                    repeat (63 - s - 1) ps();
                    chk("R8 one left", int'(backoff_o), 1);
                    chk("R10 wait", int'(tx_permit_o), 0);
                end
                if (63 - s > 0) ps();
                chk("R8 zero", int'(backoff_o), 0);
                chk("R10 permit", int'(tx_permit_o), 1);
                ps();
                chk("R8 hold zero", int'(backoff_o), 0);
            end
        end

        // R7 / R1 / R11 random backoff through retry limit
        det_mode_i = 1'b0;
        pf();
        for (int k = 1; k <= 8; k++) begin
            int b;
            do_coll();
            chk("R1 history", int'(coll_hist_o), (1 << k) - 1);
            chk("R7 masked load", int'(backoff_o & ~coll_hist_o), 0);
            chk("R11 disable", int'(tx_disable_o), (k >= 8) ? 1 : 0);
            b = int'(backoff_o);
            for (int t = 0; t < b; t++) ps();
            chk("R8 random count", int'(backoff_o), 0);
            chk("R11 permit", int'(tx_permit_o), (k >= 8) ? 0 : 1);
        end
        pf();
        chk("R11 cleared", int'(tx_disable_o), 0);
        chk("R1 cleared", int'(coll_hist_o), 0);
        chk("R10 new frame", int'(tx_permit_o), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule